// File: doc/BRIEF.md
# Memory Controller Configuration Register Bank

This block is the software-visible register file of an error-correcting memory controller. A host reaches nine 32-bit words over a simple word-addressed bus with separate read and write strobes. The block applies a write mask to each word, merges a read-only chip identifier into the enable word, and holds the last reported memory fault (status plus two address words). It raises one interrupt line when a reported fault warrants it. Software clears the line by writing the fault status word.

A build-time parameter selects one of three chip variants. The variant changes the enable-word write mask, the bits kept by a soft reset, and whether a small byte-wide diagnostic window exists. Only variant 0 has the window: four bytes, each addressed on its own. The datapath reports faults on a one-cycle pulse, together with the error kind, the syndrome, the double-word index and the two address words.

Top module: `ecc_cfg_bank`

## Requirements
- R1: After power-on reset, word 0 (enable) reads as the variant number placed in bits 31:28, word 1 (delay) reads 0x00000020, word 4 (fault address 0) reads 0x07C00000, all other words read zero, and `irq` is low.
- R2: A write to word 0 stores data AND 0x00000103 for variant 0. For variants 1 and 2 it stores (data AND 0x00000BFF) OR (variant << 28), so the identifier bits never change.
- R3: A write to word 1 stores the data with bit 31 forced to zero.
- R4: A write to word 2 (fault status) stores the written value as is and drives `irq` low on the following cycle, even when a fault is reported in the same cycle.
- R5: A `soft_rst` cycle keeps only enable bit 8 for variant 0. For other variants it keeps enable bits 31:24, 11 and 9:2. It loads the R1 values into every other word and drops `irq`.
- R6: Words 4 and 5 (fault address 0 and 1) ignore bus writes.
- R7: For variant 0, a diagnostic byte written at `diag_addr` reads back from the same index one cycle after a `diag_rd`. For other variants `diag_rdata` is always zero.
- R8: Words 3, 6, 7 and 8 each store all 32 written bits independently. A write to one leaves the others unchanged.
- R9: A `fault_valid` pulse with `fault_ce` or `fault_ue` set loads word 2 as follows: bit 0 = correctable, bit 3 = uncorrectable, bits 7:4 = double-word index, bits 15:8 = syndrome, bit 16 = multiple error. The same pulse loads words 4 and 5 from `fault_addr0`/`fault_addr1`. Bit 16 is set when bit 0, bit 3 or bit 16 was already set before the pulse.
- R10: A captured fault sets `irq` only if enable bit 0 is set, and only when the fault is uncorrectable or enable bit 1 is set. `irq` stays high until cleared by R4 or R5.
- R11: Word offsets 9 to 15 read as zero, and writes to them change no register.
- R12: `reg_rdata` carries the addressed word in the cycle after `reg_rd` is sampled high and reads zero after any cycle without `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous controller reset with field retention |
| reg_addr | input | ADDR_W | Byte address; bits above 1 select the word |
| reg_wr | input | 1 | Word write strobe |
| reg_rd | input | 1 | Word read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| diag_addr | input | DIAG_AW | Diagnostic byte index |
| diag_wr | input | 1 | Diagnostic byte write strobe |
| diag_rd | input | 1 | Diagnostic byte read strobe |
| diag_wdata | input | 8 | Diagnostic write byte |
| diag_rdata | output | 8 | Registered diagnostic read byte |
| fault_valid | input | 1 | Fault report pulse |
| fault_ce | input | 1 | Reported fault is correctable |
| fault_ue | input | 1 | Reported fault is uncorrectable |
| fault_dw | input | 4 | Double-word index of the fault |
| fault_syn | input | 8 | Syndrome of the fault |
| fault_addr0 | input | 32 | Fault address word 0 to capture |
| fault_addr1 | input | 32 | Fault address word 1 to capture |
| irq | output | 1 | Fault interrupt, level |

## Verification
The bench runs a variant-1 and a variant-0 instance side by side, so each write checks both mask tables at once. A swapped mask or a dropped identifier OR shows up as a differing top nibble or stray low bits. The cases it targets include back-to-back faults, where a design that misses the multiple-error flag leaves bit 16 clear, and faults under each enable-bit combination, where a wrong gating term raises a spurious interrupt or misses a needed one. It also covers a soft reset after all enable bits were written, where a wrong retention mask keeps or loses bits. The event-count pair is checked for cross-aliasing, and unmapped offsets are written and then read to expose decode aliasing into real registers.

// File: rtl/ecc_cfg_pkg.sv
package ecc_cfg_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_REGS = 9;
  localparam int DW_W     = 4;
  localparam int SYN_W    = 8;

  // word indices; the order is the software address map
  localparam int IX_ENA    = 0;
  localparam int IX_DLY    = 1;
  localparam int IX_FSTAT  = 2;
  localparam int IX_VIDEO  = 3;
  localparam int IX_FADDR0 = 4;
  localparam int IX_FADDR1 = 5;
  localparam int IX_DIAG   = 6;
  localparam int IX_EVT0   = 7;
  localparam int IX_EVT1   = 8;

  localparam logic [WORD_W-1:0] DLY_WMASK    = 32'h7FFF_FFFF;
  localparam logic [WORD_W-1:0] DLY_RST      = 32'h0000_0020;
  localparam logic [WORD_W-1:0] FADDR0_RST   = 32'h07C0_0000;
  localparam logic [WORD_W-1:0] ENA_WMASK_V0 = 32'h0000_0103;
  localparam logic [WORD_W-1:0] ENA_WMASK_VX = 32'h0000_0BFF;
  localparam logic [WORD_W-1:0] ENA_KEEP_V0  = 32'h0000_0100;
  localparam logic [WORD_W-1:0] ENA_KEEP_VX  = 32'hFF00_0BFC;

  localparam int FS_CE = 0;
  localparam int FS_UE = 3;
  localparam int FS_ME = 16;

  function automatic logic [WORD_W-1:0] variant_id(input int v);
    variant_id = {v[3:0], 28'h0};
  endfunction

  function automatic logic [WORD_W-1:0] ena_on_write(input int v,
                                                     input logic [WORD_W-1:0] d);
    if (v == 0) ena_on_write = d & ENA_WMASK_V0;
    else        ena_on_write = variant_id(v) | (d & ENA_WMASK_VX);
  endfunction

  function automatic logic [WORD_W-1:0] ena_on_soft(input int v,
                                                    input logic [WORD_W-1:0] q);
    if (v == 0) ena_on_soft = q & ENA_KEEP_V0;
    else        ena_on_soft = q & ENA_KEEP_VX;
  endfunction

  function automatic logic [WORD_W-1:0] fstat_pack(input logic ce, input logic ue,
                                                   input logic [DW_W-1:0] dw,
                                                   input logic [SYN_W-1:0] syn,
                                                   input logic me);
    logic [WORD_W-1:0] r;
    r = '0;
    r[FS_CE] = ce;
    r[FS_UE] = ue;
    r[7:4]   = dw;
    r[15:8]  = syn;
    r[FS_ME] = me;
    fstat_pack = r;
  endfunction
endpackage

// File: rtl/ecc_cfg_ctrl.sv
module ecc_cfg_ctrl
  import ecc_cfg_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic [NUM_REGS-1:0] wr_sel,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   ena_q,
  output logic [WORD_W-1:0]   dly_q,
  output logic [WORD_W-1:0]   video_q,
  output logic [WORD_W-1:0]   diag_q,
  output logic [WORD_W-1:0]   evt0_q,
  output logic [WORD_W-1:0]   evt1_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q   <= variant_id(VARIANT);
      dly_q   <= DLY_RST;
      video_q <= '0;
      diag_q  <= '0;
      evt0_q  <= '0;
      evt1_q  <= '0;
    end else if (soft_rst) begin
      ena_q   <= ena_on_soft(VARIANT, ena_q);
      dly_q   <= DLY_RST;
      video_q <= '0;
      diag_q  <= '0;
      evt0_q  <= '0;
      evt1_q  <= '0;
    end else begin
      if (wr_sel[IX_ENA])   ena_q   <= ena_on_write(VARIANT, wdata);
      if (wr_sel[IX_DLY])   dly_q   <= wdata & DLY_WMASK;
      if (wr_sel[IX_VIDEO]) video_q <= wdata;
      if (wr_sel[IX_DIAG])  diag_q  <= wdata;
      if (wr_sel[IX_EVT0])  evt0_q  <= wdata;
      if (wr_sel[IX_EVT1])  evt1_q  <= wdata;
    end
  end
endmodule

// File: rtl/ecc_cfg_fault.sv
module ecc_cfg_fault
  import ecc_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              fstat_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              chk_en,
  input  logic              ce_irq_en,
  input  logic              fault_valid,
  input  logic              fault_ce,
  input  logic              fault_ue,
  input  logic [DW_W-1:0]   fault_dw,
  input  logic [SYN_W-1:0]  fault_syn,
  input  logic [WORD_W-1:0] fault_addr0,
  input  logic [WORD_W-1:0] fault_addr1,
  output logic [WORD_W-1:0] fstat_q,
  output logic [WORD_W-1:0] faddr0_q,
  output logic [WORD_W-1:0] faddr1_q,
  output logic              irq_q,
  output logic              fault_take
);
  logic had_err;
  logic raise;

  assign fault_take = fault_valid && (fault_ce || fault_ue) && !fstat_wr && !soft_rst;
  assign had_err    = fstat_q[FS_CE] || fstat_q[FS_UE] || fstat_q[FS_ME];
  assign raise      = chk_en && (fault_ue || (fault_ce && ce_irq_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fstat_q  <= '0;
      faddr0_q <= FADDR0_RST;
      faddr1_q <= '0;
      irq_q    <= 1'b0;
    end else if (soft_rst) begin
      fstat_q  <= '0;
      faddr0_q <= FADDR0_RST;
      faddr1_q <= '0;
      irq_q    <= 1'b0;
    end else if (fstat_wr) begin
      fstat_q <= wdata;
      irq_q   <= 1'b0;
    end else if (fault_take) begin
      fstat_q  <= fstat_pack(fault_ce, fault_ue, fault_dw, fault_syn, had_err);
      faddr0_q <= fault_addr0;
      faddr1_q <= fault_addr1;
      if (raise) irq_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ecc_cfg_diag.sv
module ecc_cfg_diag #(
  parameter int NBYTES = 4,
  localparam int AW    = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] bytes_q [NBYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
      rdata <= '0;
    end else begin
      if (wr) bytes_q[addr] <= wdata;
      rdata <= rd ? bytes_q[addr] : 8'h00;
    end
  end
endmodule

// File: rtl/ecc_cfg_bank.sv
module ecc_cfg_bank
  import ecc_cfg_pkg::*;
#(
  parameter int VARIANT    = 0,
  parameter int ADDR_W     = 6,
  parameter int DIAG_BYTES = 4,
  localparam int DIAG_AW   = $clog2(DIAG_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [DIAG_AW-1:0] diag_addr,
  input  logic               diag_wr,
  input  logic               diag_rd,
  input  logic [7:0]         diag_wdata,
  output logic [7:0]         diag_rdata,
  input  logic               fault_valid,
  input  logic               fault_ce,
  input  logic               fault_ue,
  input  logic [3:0]         fault_dw,
  input  logic [7:0]         fault_syn,
  input  logic [31:0]        fault_addr0,
  input  logic [31:0]        fault_addr1,
  output logic               irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    reg_idx;
  logic [NUM_REGS-1:0] wr_sel;
  logic [WORD_W-1:0]   ena_q, dly_q, video_q, diagw_q, evt0_q, evt1_q;
  logic [WORD_W-1:0]   fstat_q, faddr0_q, faddr1_q;
  logic [WORD_W-1:0]   rd_mux;
  logic                fault_take;
  logic                unused_lsb;

  assign reg_idx    = reg_addr[ADDR_W-1:2];
  assign unused_lsb = ^reg_addr[1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wsel
    assign wr_sel[g] = reg_wr && (reg_idx == IDX_W'(g));
  end

  ecc_cfg_ctrl #(.VARIANT(VARIANT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_sel(wr_sel), .wdata(reg_wdata),
    .ena_q(ena_q), .dly_q(dly_q), .video_q(video_q),
    .diag_q(diagw_q), .evt0_q(evt0_q), .evt1_q(evt1_q)
  );

  ecc_cfg_fault u_fault (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .fstat_wr(wr_sel[IX_FSTAT]), .wdata(reg_wdata),
    .chk_en(ena_q[0]), .ce_irq_en(ena_q[1]),
    .fault_valid(fault_valid), .fault_ce(fault_ce), .fault_ue(fault_ue),
    .fault_dw(fault_dw), .fault_syn(fault_syn),
    .fault_addr0(fault_addr0), .fault_addr1(fault_addr1),
    .fstat_q(fstat_q), .faddr0_q(faddr0_q), .faddr1_q(faddr1_q),
    .irq_q(irq), .fault_take(fault_take)
  );

  if (VARIANT == 0) begin : g_diag
    ecc_cfg_diag #(.NBYTES(DIAG_BYTES)) u_diag (
      .clk(clk), .rst_n(rst_n), .wr(diag_wr), .rd(diag_rd),
      .addr(diag_addr), .wdata(diag_wdata), .rdata(diag_rdata)
    );
  end else begin : g_nodiag
    logic unused_diag;
    assign unused_diag = ^{diag_wr, diag_rd, diag_addr, diag_wdata};
    assign diag_rdata  = 8'h00;
  end

  always_comb begin
    case (int'(reg_idx))
      IX_ENA:    rd_mux = ena_q;
      IX_DLY:    rd_mux = dly_q;
      IX_FSTAT:  rd_mux = fstat_q;
      IX_VIDEO:  rd_mux = video_q;
      IX_FADDR0: rd_mux = faddr0_q;
      IX_FADDR1: rd_mux = faddr1_q;
      IX_DIAG:   rd_mux = diagw_q;
      IX_EVT0:   rd_mux = evt0_q;
      IX_EVT1:   rd_mux = evt1_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= reg_rd ? rd_mux : '0;
  end
endmodule

// File: rtl/ecc_cfg_bank_chk.sv
module ecc_cfg_bank_chk #(
  parameter int VARIANT = 0,
  parameter int ADDR_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-3:0] reg_idx,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [31:0]       reg_rdata,
  input logic              irq,
  input logic [31:0]       ena_q,
  input logic [31:0]       fstat_q,
  input logic              fault_take
);
  if (VARIANT == 0) begin : g_v0
    p_ena_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_q & ~32'h0000_0103) == 32'h0);
  end else begin : g_vx
    p_ena_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ena_q[31:28] == VARIANT[3:0]);
  end

  p_dly_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_idx == (ADDR_W-2)'(1)) |=> !reg_rdata[31]);

  p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == (ADDR_W-2)'(2)) |=> !irq);

  p_me_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_take && (fstat_q[0] || fstat_q[3])) |=> fstat_q[16]);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(fault_take) && $past(ena_q[0])));

  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_idx > (ADDR_W-2)'(8)) |=> reg_rdata == 32'h0);

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> reg_rdata == 32'h0);
endmodule

bind ecc_cfg_bank ecc_cfg_bank_chk #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_ecc_cfg_bank.sv
module test_ecc_cfg_bank;
  logic        clk = 1'b0;
  logic        rst_n, soft_rst;
  logic [5:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata;
  logic [31:0] rd_v1, rd_v0;
  logic [1:0]  diag_addr;
  logic        diag_wr, diag_rd;
  logic [7:0]  diag_wdata, dg_v1, dg_v0;
  logic        fault_valid, fault_ce, fault_ue;
  logic [3:0]  fault_dw;
  logic [7:0]  fault_syn;
  logic [31:0] fault_addr0, fault_addr1;
  logic        irq_v1, irq_v0;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  ecc_cfg_bank #(.VARIANT(1)) i_ecc_cfg_bank (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(rd_v1),
    .diag_addr(diag_addr), .diag_wr(diag_wr), .diag_rd(diag_rd),
    .diag_wdata(diag_wdata), .diag_rdata(dg_v1),
    .fault_valid(fault_valid), .fault_ce(fault_ce), .fault_ue(fault_ue),
    .fault_dw(fault_dw), .fault_syn(fault_syn),
    .fault_addr0(fault_addr0), .fault_addr1(fault_addr1), .irq(irq_v1));

  ecc_cfg_bank #(.VARIANT(0)) i_ecc_cfg_bank_v0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(rd_v0),
    .diag_addr(diag_addr), .diag_wr(diag_wr), .diag_rd(diag_rd),
    .diag_wdata(diag_wdata), .diag_rdata(dg_v0),
    .fault_valid(fault_valid), .fault_ce(fault_ce), .fault_ue(fault_ue),
    .fault_dw(fault_dw), .fault_syn(fault_syn),
    .fault_addr0(fault_addr0), .fault_addr1(fault_addr1), .irq(irq_v0));

  function automatic logic [31:0] m_reset(input int v, input int w);
    case (w)
      0: m_reset = v == 0 ? 32'h0 : (32'(v) << 28);
      1: m_reset = 32'h20;
      4: m_reset = 32'h07C0_0000;
      default: m_reset = 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_ena(input int v, input logic [31:0] d);
    if (v == 0) m_ena = {23'h0, d[8], 6'h0, d[1:0]};
    else        m_ena = (32'(v) << 28) + {20'h0, d[11], 1'b0, d[9:0]};
  endfunction

  function automatic logic [31:0] m_stat(input logic ce, input logic ue,
                                         input logic [3:0] dw, input logic [7:0] s,
                                         input logic me);
    m_stat = {15'h0, me, s, dw, ue, 2'b00, ce};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(w << 2); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int w, output logic [31:0] a1, output logic [31:0] a0);
    @(negedge clk);
    reg_addr = 6'(w << 2) | 6'(w & 3); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    a1 = rd_v1; a0 = rd_v0;
  endtask

  task automatic fault(input logic ce, input logic ue, input logic [3:0] dw,
                       input logic [7:0] s, input logic [31:0] a0, input logic [31:0] a1);
    @(negedge clk);
    fault_valid = 1'b1; fault_ce = ce; fault_ue = ue; fault_dw = dw; fault_syn = s;
    fault_addr0 = a0; fault_addr1 = a1;
    @(negedge clk);
    fault_valid = 1'b0;
  endtask

  task automatic both(input string req, input int w, input logic [31:0] e1, input logic [31:0] e0);
    logic [31:0] a1, a0;
    rd(w, a1, a0);
    check(req, a1, e1);
    check(req, a0, e0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, dly_exp, st, a1, a0;
    logic        ib;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; soft_rst = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_wdata = '0; diag_addr = '0; diag_wr = 1'b0; diag_rd = 1'b0; diag_wdata = '0;
    fault_valid = 1'b0; fault_ce = 1'b0; fault_ue = 1'b0; fault_dw = '0; fault_syn = '0;
    fault_addr0 = '0; fault_addr1 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 power-on values
    for (int w = 0; w < 9; w++) both("R1", w, m_reset(1, w), m_reset(0, w));
    check("R1 irq", {30'h0, irq_v1, irq_v0}, 32'h0);

    // R12 read data returns to zero when idle
    rd(1, a1, a0);
    @(negedge clk);
    check("R12", rd_v1 | rd_v0, 32'h0);

    // R2 enable masks, directed then random
    for (int i = 0; i < 24; i++) begin
      d = (i == 0) ? 32'hFFFF_FFFF : (i == 1) ? 32'h0 : $urandom;
      wr(0, d);
      both("R2", 0, m_ena(1, d), m_ena(0, d));
    end

    // R3 delay bit 31 forced low
    for (int i = 0; i < 8; i++) begin
      d = (i == 0) ? 32'hFFFF_FFFF : $urandom;
      wr(1, d);
      dly_exp = {1'b0, d[30:0]};
      both("R3", 1, dly_exp, dly_exp);
    end

    // R8 independent storage words
    wr(3, 32'hA1B2_C3D4); wr(6, 32'h1357_9BDF); wr(7, 32'hDEAD_0007); wr(8, 32'hBEEF_0008);
    both("R8 video", 3, 32'hA1B2_C3D4, 32'hA1B2_C3D4);
    both("R8 diagw", 6, 32'h1357_9BDF, 32'h1357_9BDF);
    both("R8 evt0", 7, 32'hDEAD_0007, 32'hDEAD_0007);
    both("R8 evt1", 8, 32'hBEEF_0008, 32'hBEEF_0008);

    // R6 fault address words ignore writes
    wr(4, 32'h1111_1111); wr(5, 32'h2222_2222);
    both("R6 faddr0", 4, 32'h07C0_0000, 32'h07C0_0000);
    both("R6 faddr1", 5, 32'h0, 32'h0);

    // R11 unmapped offsets
    for (int w = 9; w < 16; w++) begin
      wr(w, $urandom | 32'h8000_0001);
      both("R11", w, 32'h0, 32'h0);
    end
    both("R11 no alias dly", 1, dly_exp, dly_exp);
    both("R11 no alias evt1", 8, 32'hBEEF_0008, 32'hBEEF_0008);

    // R9 / R10 directed faults
    wr(0, 32'h3);
    fault(1'b1, 1'b0, 4'h5, 8'hA5, 32'hCAFE_0001, 32'h0000_0077);
    check("R10 ce irq", {30'h0, irq_v1, irq_v0}, 32'h3);
    both("R9 stat", 2, m_stat(1, 0, 4'h5, 8'hA5, 0), m_stat(1, 0, 4'h5, 8'hA5, 0));
    both("R9 addr0", 4, 32'hCAFE_0001, 32'hCAFE_0001);
    both("R9 addr1", 5, 32'h0000_0077, 32'h0000_0077);
    fault(1'b0, 1'b1, 4'h2, 8'h3C, 32'h0, 32'h1);
    both("R9 multi", 2, m_stat(0, 1, 4'h2, 8'h3C, 1), m_stat(0, 1, 4'h2, 8'h3C, 1));
    check("R10 stays", {30'h0, irq_v1, irq_v0}, 32'h3);
    wr(2, 32'h0000_1234);
    check("R4 irq low", {30'h0, irq_v1, irq_v0}, 32'h0);
    both("R4 stored", 2, 32'h0000_1234, 32'h0000_1234);
    wr(2, 32'h0);
    wr(0, 32'h1);
    fault(1'b1, 1'b0, 4'h1, 8'h11, 32'h5, 32'h6);
    check("R10 ce masked", {30'h0, irq_v1, irq_v0}, 32'h0);
    fault(1'b0, 1'b1, 4'h1, 8'h11, 32'h5, 32'h6);
    check("R10 ue", {30'h0, irq_v1, irq_v0}, 32'h3);
    wr(2, 32'h0);
    wr(0, 32'h2);
    fault(1'b0, 1'b1, 4'h9, 8'h99, 32'h5, 32'h6);
    check("R10 chk off", {30'h0, irq_v1, irq_v0}, 32'h0);

    // R4 write beats a simultaneous fault
    wr(0, 32'h3);
    @(negedge clk);
    fault_valid = 1'b1; fault_ce = 1'b0; fault_ue = 1'b1;
    reg_addr = 6'h08; reg_wdata = 32'h0000_0040; reg_wr = 1'b1;
    @(negedge clk);
    fault_valid = 1'b0; reg_wr = 1'b0;
    check("R4 priority irq", {30'h0, irq_v1, irq_v0}, 32'h0);
    both("R4 priority stat", 2, 32'h40, 32'h40);
    wr(2, 32'h0);

    // R9 / R10 random faults against a model
    st = 32'h0; ib = 1'b0;
    for (int i = 0; i < 30; i++) begin
      logic [1:0] en;
      logic ce, ue;
      logic [3:0] dw;
      logic [7:0] sy;
      en = 2'($urandom); ce = 1'($urandom); ue = 1'($urandom);
      dw = 4'($urandom); sy = 8'($urandom);
      wr(0, {30'h0, en});
      fault(ce, ue, dw, sy, 32'(i), 32'(i + 100));
      if (ce || ue) begin
        st = m_stat(ce, ue, dw, sy, st[0] | st[3] | st[16]);
        if (en[0] && (ue || (ce && en[1]))) ib = 1'b1;
      end
      check("R10 rand irq", {30'h0, irq_v1, irq_v0}, {30'h0, ib, ib});
      both("R9 rand stat", 2, st, st);
      if ($urandom % 3 == 0) begin
        wr(2, 32'h0); st = 32'h0; ib = 1'b0;
      end
    end

    // R5 soft reset retention
    wr(0, 32'hFFFF_FFFF); wr(1, 32'h1234_5678); wr(7, 32'h77);
    fault(1'b0, 1'b1, 4'h3, 8'h33, 32'hAAAA_0000, 32'hBBBB_0000);
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk) soft_rst = 1'b0;
    both("R5 ena", 0, 32'h1000_0BFC, 32'h0000_0100);
    for (int w = 1; w < 9; w++) both("R5", w, m_reset(1, w), m_reset(0, w));
    check("R5 irq", {30'h0, irq_v1, irq_v0}, 32'h0);

    // R7 diagnostic window
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      diag_addr = 2'(b); diag_wdata = 8'h5A ^ 8'(b * 37); diag_wr = 1'b1;
    end
    @(negedge clk) diag_wr = 1'b0;
    for (int b = 3; b >= 0; b--) begin
      @(negedge clk);
      diag_addr = 2'(b); diag_rd = 1'b1;
      @(negedge clk);
      diag_rd = 1'b0;
      check("R7 v0 byte", {24'h0, dg_v0}, {24'h0, 8'h5A ^ 8'(b * 37)});
      check("R7 v1 absent", {24'h0, dg_v1}, 32'h0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule